// File: doc/BRIEF.md
# Seconds Counter with Alarm

This block keeps wall-clock time as one 47-bit binary count. The upper 32 bits hold whole seconds, and the lower 15 bits hold the fraction of a second. The count is advanced by a tick strobe at 32.768 kHz, so the fraction rolls over into the seconds word once per second. The tick, the register-write strobes and the freeze inputs arrive already synchronised to the block clock. Crossing the low-power clock domain, the bus decode and the tamper logic all sit outside this block.

The count moves only when all of these hold:
- the run-enable bit is set;
- no overflow is pending;
- the unit is neither in its non-valid condition nor in its failure condition.

When the count is all ones and one more tick arrives, the count stays where it is and an overflow flag is raised. Counting remains stopped until software clears that flag.

A 32-bit alarm register is compared with the seconds word only. When the seconds first reach the alarm value, an alarm flag is raised, and that flag drives an interrupt when the alarm interrupt enable is set. An alarm value of all ones means no alarm is armed. Both flags are cleared by writing a one to their bit.

Top module: `rtc_sec_alarm`

## Requirements
- R1: After reset, seconds and fraction read zero, the alarm register reads all ones, both flags are low and irq_o is low.
- R2: A cycle with tick_i and run_en_i both high adds one to the 47-bit count {sec_o, frac_o}, visible after that clock edge. A carry out of the 15-bit fraction increments the seconds. With run_en_i low, ticks leave the count unchanged.
- R3: A tick that would advance an all-ones count leaves the count at all ones and sets ovf_flag_o at the same edge. While ovf_flag_o is high, ticks leave the count unchanged.
- R4: While nonvalid_i or failure_i is high, ticks leave the count unchanged.
- R5: ld_sec_i loads sec_o from wr_data_i and leaves frac_o unchanged. ld_frac_i loads frac_o from wr_data_i[14:0] and leaves sec_o unchanged. A load in the same cycle as a tick takes effect instead of the increment.
- R6: flag_clr_i is write-one-to-clear. Bit 0 clears the overflow flag and bit 1 clears the alarm flag; a zero bit leaves its flag unchanged.
- R7: alm_flag_o sets at the clock edge after sec_o first becomes equal to alm_o. The fraction is not compared, and the flag is not set again while the equality persists.
- R8: ld_alm_i loads alm_o from wr_data_i. An alarm value of all ones never sets alm_flag_o, even when sec_o is all ones.
- R9: irq_o is high in a cycle exactly when alm_flag_o is high and alm_irq_en_i was high at the preceding clock edge.
- R10: Once the overflow flag is cleared, ticks advance the count again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One pulse per 32.768 kHz period |
| run_en_i | input | 1 | Time counter enable bit |
| nonvalid_i | input | 1 | Unit is in the non-valid condition (freezes the count) |
| failure_i | input | 1 | Unit is in the failure condition (freezes the count) |
| wr_data_i | input | 32 | Write data for the load strobes |
| ld_sec_i | input | 1 | Load the seconds word |
| ld_frac_i | input | 1 | Load the fraction |
| ld_alm_i | input | 1 | Load the alarm seconds |
| flag_clr_i | input | 2 | Write-one-to-clear: bit 0 clears overflow, bit 1 clears alarm |
| alm_irq_en_i | input | 1 | Alarm interrupt enable |
| sec_o | output | 32 | Seconds count |
| frac_o | output | 15 | Sub-second fraction |
| alm_o | output | 32 | Alarm seconds value |
| ovf_flag_o | output | 1 | Overflow flag |
| alm_flag_o | output | 1 | Alarm flag |
| irq_o | output | 1 | Alarm interrupt |

## Verification
Counting is exercised from a table of load-then-tick patterns. These cover:
- a plain fraction step;
- a single carry from a full fraction;
- a carry crossing a 16-bit boundary of the seconds word;
- a full 32768-tick second;
- a zero-tick load.

Together these separate a correct carry chain from one that truncates or mis-splits the two fields.

Directed runs cover the following:
- Each gating condition on its own: the enable, non-valid, failure and a pending overflow.
- The all-ones count, which shows that the block holds the count rather than wrapping it.
- An alarm reached by a carry rather than by a load.
- The unset alarm value placed against an all-ones seconds word.
- Flag clearing with the wrong bit, to show that each flag clears only from its own bit.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned NUM_FLAGS = 2;
  localparam int unsigned FLG_OVF   = 0;
  localparam int unsigned FLG_ALM   = 1;
endpackage

// File: rtl/rtc_tick_counter.sv
module rtc_tick_counter #(
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned FRAC_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              run_en_i,
  input  logic              freeze_i,
  input  logic              ovf_i,
  input  logic              ld_sec_i,
  input  logic              ld_frac_i,
  input  logic [SEC_W-1:0]  wr_data_i,
  output logic [SEC_W-1:0]  sec_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic              ovf_set_o
);
  localparam int unsigned CNT_W = SEC_W + FRAC_W;

  logic [CNT_W-1:0] cnt_q;
  logic             advance;
  logic             any_ld;
  logic             at_top;

  assign any_ld    = ld_sec_i | ld_frac_i;
  assign at_top    = &cnt_q;
  assign advance   = tick_i & run_en_i & ~freeze_i & ~ovf_i & ~any_ld;
  assign ovf_set_o = advance & at_top;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (any_ld) begin
      if (ld_sec_i)  cnt_q[CNT_W-1:FRAC_W] <= wr_data_i;
      if (ld_frac_i) cnt_q[FRAC_W-1:0]     <= wr_data_i[FRAC_W-1:0];
    end else if (advance && !at_top) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sec_o  = cnt_q[CNT_W-1:FRAC_W];
  assign frac_o = cnt_q[FRAC_W-1:0];

  // R3: a pending overflow holds the count unless software loads it
  a_r3_hold_on_ovf: assert property (@(posedge clk) disable iff (rst)
    (ovf_i && !any_ld) |=> $stable(cnt_q));

  // R4: the freeze conditions hold the count
  a_r4_freeze_hold: assert property (@(posedge clk) disable iff (rst)
    (freeze_i && !any_ld) |=> $stable(cnt_q));

  // R2: with the enable off the count does not move
  a_r2_disabled_hold: assert property (@(posedge clk) disable iff (rst)
    (!run_en_i && !any_ld) |=> $stable(cnt_q));
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int unsigned SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_alm_i,
  input  logic [SEC_W-1:0] wr_data_i,
  input  logic [SEC_W-1:0] sec_i,
  output logic [SEC_W-1:0] alm_o,
  output logic             hit_o
);
  logic [SEC_W-1:0] alm_q;
  logic             match;
  logic             match_q;
  logic             armed;

  assign armed = ~(&alm_q);
  assign match = armed && (sec_i == alm_q);
  assign hit_o = match & ~match_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      alm_q   <= '1;
      match_q <= 1'b0;
    end else begin
      if (ld_alm_i) alm_q <= wr_data_i;
      match_q <= match;
    end
  end

  assign alm_o = alm_q;

  // R8: the unset value never produces a hit
  a_r8_unset_no_hit: assert property (@(posedge clk) disable iff (rst)
    (&alm_o) |-> !hit_o);

  // R7: a hit fires only on the first cycle of equality
  a_r7_single_hit: assert property (@(posedge clk) disable iff (rst)
    hit_o |=> !hit_o);
endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank
  import rtc_pkg::*;
#(
  parameter int unsigned NF = NUM_FLAGS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  input  logic          irq_en_i,
  output logic [NF-1:0] flag_o,
  output logic          irq_o
);
  logic [NF-1:0] flag_q;
  logic [NF-1:0] flag_d;
  logic          irq_q;

  for (genvar i = 0; i < NF; i++) begin : g_flag
    assign flag_d[i] = set_i[i] | (flag_q[i] & ~clr_i[i]);

    always_ff @(posedge clk) begin
      if (rst) flag_q[i] <= 1'b0;
      else     flag_q[i] <= flag_d[i];
    end

    // R6: a flag drops only through its own clear bit
    a_r6_clear_only: assert property (@(posedge clk) disable iff (rst)
      (flag_q[i] && !clr_i[i]) |=> flag_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= flag_d[FLG_ALM] & irq_en_i;
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;

  // R9: the interrupt never fires without the alarm flag
  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> flag_o[FLG_ALM]);
endmodule

// File: rtl/rtc_sec_alarm.sv
module rtc_sec_alarm
  import rtc_pkg::*;
#(
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned FRAC_W = 15
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_i,
  input  logic                 run_en_i,
  input  logic                 nonvalid_i,
  input  logic                 failure_i,
  input  logic [SEC_W-1:0]     wr_data_i,
  input  logic                 ld_sec_i,
  input  logic                 ld_frac_i,
  input  logic                 ld_alm_i,
  input  logic [NUM_FLAGS-1:0] flag_clr_i,
  input  logic                 alm_irq_en_i,
  output logic [SEC_W-1:0]     sec_o,
  output logic [FRAC_W-1:0]    frac_o,
  output logic [SEC_W-1:0]     alm_o,
  output logic                 ovf_flag_o,
  output logic                 alm_flag_o,
  output logic                 irq_o
);
  logic [NUM_FLAGS-1:0] flags;
  logic [NUM_FLAGS-1:0] flag_set;
  logic                 ovf_set;
  logic                 alm_hit;

  rtc_tick_counter #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick_i),
    .run_en_i  (run_en_i),
    .freeze_i  (nonvalid_i | failure_i),
    .ovf_i     (flags[FLG_OVF]),
    .ld_sec_i  (ld_sec_i),
    .ld_frac_i (ld_frac_i),
    .wr_data_i (wr_data_i),
    .sec_o     (sec_o),
    .frac_o    (frac_o),
    .ovf_set_o (ovf_set)
  );

  rtc_alarm_cmp #(.SEC_W(SEC_W)) u_alm (
    .clk       (clk),
    .rst       (rst),
    .ld_alm_i  (ld_alm_i),
    .wr_data_i (wr_data_i),
    .sec_i     (sec_o),
    .alm_o     (alm_o),
    .hit_o     (alm_hit)
  );

  always_comb begin
    flag_set          = '0;
    flag_set[FLG_OVF] = ovf_set;
    flag_set[FLG_ALM] = alm_hit;
  end

  rtc_flag_bank #(.NF(NUM_FLAGS)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .set_i    (flag_set),
    .clr_i    (flag_clr_i),
    .irq_en_i (alm_irq_en_i),
    .flag_o   (flags),
    .irq_o    (irq_o)
  );

  assign ovf_flag_o = flags[FLG_OVF];
  assign alm_flag_o = flags[FLG_ALM];

  // R3: overflow rises only while the count is all ones
  a_r3_ovf_at_top: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag_o) |-> ((&sec_o) && (&frac_o)));

  // R7: alarm rises only when the seconds equal the alarm
  a_r7_alarm_match: assert property (@(posedge clk) disable iff (rst)
    $rose(alm_flag_o) |-> $past(sec_o == alm_o));
endmodule

// File: tb/rtc_sec_alarm_test.sv
module rtc_sec_alarm_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        tick_i, run_en_i, nonvalid_i, failure_i;
  logic [31:0] wr_data_i;
  logic        ld_sec_i, ld_frac_i, ld_alm_i;
  logic [1:0]  flag_clr_i;
  logic        alm_irq_en_i;
  logic [31:0] sec_o, alm_o;
  logic [14:0] frac_o;
  logic        ovf_flag_o, alm_flag_o, irq_o;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;

  always #5 clk = ~clk;

  rtc_sec_alarm uut (.*);

  localparam int NV = 6;
  localparam logic [31:0] V_SEC  [NV] = '{32'd0, 32'd5, 32'd10, 32'h0000FFFF, 32'd100, 32'd7};
  localparam logic [14:0] V_FRAC [NV] = '{15'd0, 15'h7FFF, 15'h7FFE, 15'h7FFF, 15'd0, 15'd100};
  localparam int          V_N    [NV] = '{1, 1, 3, 2, 32768, 0};
  localparam logic [31:0] E_SEC  [NV] = '{32'd0, 32'd6, 32'd11, 32'h00010000, 32'd101, 32'd7};
  localparam logic [14:0] E_FRAC [NV] = '{15'd1, 15'd0, 15'd1, 15'd1, 15'd0, 15'd100};

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [31:0] s, input logic [14:0] f);
    wr_data_i = s; ld_sec_i = 1'b1; cyc(); ld_sec_i = 1'b0;
    wr_data_i = {17'd0, f}; ld_frac_i = 1'b1; cyc(); ld_frac_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick_i = 1'b1;
    repeat (n) cyc();
    tick_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finish_run();
    end
  end

  initial begin
    rst = 1'b1; tick_i = 0; run_en_i = 0; nonvalid_i = 0; failure_i = 0;
    wr_data_i = 0; ld_sec_i = 0; ld_frac_i = 0; ld_alm_i = 0;
    flag_clr_i = 0; alm_irq_en_i = 0;
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    // R1 reset state
    chk("R1 sec", sec_o, 0);
    chk("R1 frac", frac_o, 0);
    chk("R1 alarm", alm_o, 32'hFFFFFFFF);
    chk("R1 flags", {ovf_flag_o, alm_flag_o, irq_o}, 0);

    // R2 / R5 table of load-then-tick patterns
    run_en_i = 1'b1;
    for (int i = 0; i < NV; i++) begin
      load(V_SEC[i], V_FRAC[i]);
      ticks(V_N[i]);
      chk("R2 table sec", sec_o, E_SEC[i]);
      chk("R2 table frac", frac_o, E_FRAC[i]);
    end

    // R5 each load touches only its own field
    wr_data_i = 32'd55; ld_sec_i = 1; cyc(); ld_sec_i = 0;
    chk("R5 sec load keeps frac", {sec_o, 17'd0, frac_o}, {32'd55, 17'd0, 15'd100});
    wr_data_i = 32'hFFFF0003; ld_frac_i = 1; tick_i = 1; cyc(); ld_frac_i = 0; tick_i = 0;
    chk("R5 frac load wins over tick", {sec_o, 17'd0, frac_o}, {32'd55, 17'd0, 15'd3});

    // R2 enable low holds the count
    run_en_i = 0; ticks(5);
    chk("R2 disabled hold", frac_o, 3);
    run_en_i = 1;

    // R4 non-valid and failure freeze the count
    nonvalid_i = 1; ticks(4); nonvalid_i = 0;
    chk("R4 nonvalid hold", frac_o, 3);
    failure_i = 1; ticks(4); failure_i = 0;
    chk("R4 failure hold", frac_o, 3);

    // R3 overflow at all ones
    load(32'hFFFFFFFF, 15'h7FFE);
    ticks(1);
    chk("R3 reach top", {ovf_flag_o, frac_o}, {1'b0, 15'h7FFF});
    ticks(1);
    chk("R3 ovf set", ovf_flag_o, 1);
    chk("R3 count held", {sec_o, frac_o}, {32'hFFFFFFFF, 15'h7FFF});
    // R6 wrong bit leaves the overflow flag
    flag_clr_i = 2'b10; cyc(); flag_clr_i = 0;
    chk("R6 wrong bit keeps ovf", ovf_flag_o, 1);
    flag_clr_i = 2'b01; cyc(); flag_clr_i = 0;
    chk("R6 clear ovf", ovf_flag_o, 0);
    // R10 counting resumes once cleared
    wr_data_i = 0; ld_frac_i = 1; cyc(); ld_frac_i = 0;
    ticks(2);
    chk("R10 resume", {ovf_flag_o, frac_o}, {1'b0, 15'd2});

    // R7 / R9 alarm reached by a carry
    wr_data_i = 32'd20; ld_alm_i = 1; cyc(); ld_alm_i = 0;
    chk("R8 alarm load", alm_o, 20);
    alm_irq_en_i = 1;
    load(32'd19, 15'h7FFF);
    ticks(1);
    chk("R7 flag not before edge", {sec_o, 31'd0, alm_flag_o}, {32'd20, 32'd0});
    cyc();
    chk("R7 alarm flag", alm_flag_o, 1);
    chk("R9 irq with enable", irq_o, 1);
    alm_irq_en_i = 0; cyc();
    chk("R9 irq masked", {alm_flag_o, irq_o}, 2'b10);
    flag_clr_i = 2'b01; cyc(); flag_clr_i = 0;
    chk("R6 wrong bit keeps alarm", alm_flag_o, 1);
    flag_clr_i = 2'b10; cyc(); flag_clr_i = 0;
    cyc(); cyc();
    chk("R7 no retrigger while equal", {sec_o, 31'd0, alm_flag_o}, {32'd20, 32'd0});

    // R8 unset alarm against an all-ones seconds word
    wr_data_i = 32'hFFFFFFFF; ld_alm_i = 1; cyc(); ld_alm_i = 0;
    load(32'hFFFFFFFE, 15'h7FFF);
    ticks(1); cyc(); cyc();
    chk("R8 unset never fires", {sec_o, 31'd0, alm_flag_o}, {32'hFFFFFFFF, 32'd0});

    finish_run();
  end
endmodule